// File: doc/BRIEF.md
# Reference-Clock Time Stamp Counter

This block keeps a free-running time stamp on a reference clock and derives three timing outputs from it: a stamp latched for each received packet, a square wave that follows one selectable counter bit, and a compare output that fires when the count reaches a programmed value. A small host register port configures it: a global enable, a 32-bit or 64-bit counting width, the direction of single-count rate corrections, the compare polarity and pulse/toggle behaviour, and whether received packets carry the time or a running packet sequence number.

A host can also load the counter with an absolute value, so software can align it to a remote time base. Rate corrections arrive as one-cycle pulses from an external rate generator. Each pulse either inserts one extra count or removes one count. The configuration registers live in the host clock domain, and the reference-clock logic reads them directly.

Top module: `tsync_counter`

## Requirements
- R1: After reset the control register (address 0) reads 0x00000020, the time stamp is 0, and the compare, sync and receive-event outputs are low.
- R2: Register map. Address 0 is control: bit0 enable, bit1 64-bit width, bit2 sequence mode, bit3 correction direction, bit4 compare toggle, bit5 compare polarity (1 = active-high), bit6 receive stamp enable, bit7 receive no-event, bits 11:8 sync select. Address 1 is compare low, address 2 is compare high, and address 4 is load high. A write to address 3 loads the counter with {load high, written data}. Addresses 0, 1, 2 and 4 read back what was written.
- R3: While enable is 0, the time stamp, the sequence count, the receive stamp and the compare state are all held at zero. Loads and packet strobes have no effect.
- R4: When enabled, with no correction pulse and no load, the time stamp rises by exactly 1 per reference clock.
- R5: A correction pulse with direction 0 advances the time stamp by 2 in that cycle. With direction 1 it holds the time stamp for that cycle.
- R6: In 32-bit mode bits 63:32 of the time stamp are zero and the lower half wraps from 0xFFFFFFFF to 0. In 64-bit mode the carry passes into bit 32.
- R7: A load is visible on the time stamp one clock after the write. In 32-bit mode the loaded upper half is dropped.
- R8: A sync select of 0 drives the sync output low. A value N from 1 to 15 drives it with time stamp bit 16+N.
- R9: In pulse mode the compare output is active for exactly the one clock after the time stamp equals the 64-bit compare value. Polarity 0 inverts the output level.
- R10: In toggle mode the compare output changes level once for each match.
- R11: A packet strobe with enable and stamp enable set latches the current time stamp into the receive stamp and raises the receive event for one clock. With no-event set the stamp is latched but no event is raised. With stamp enable clear, neither happens.
- R12: In sequence mode, stamped packets receive 1, 2, 3 and so on. Clearing and setting sequence mode again restarts the numbering at 1.
- R13: A packet strobe that coincides with a correction pulse stamps the pre-correction time stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hostClk | input | 1 | Register port clock |
| hostRstN | input | 1 | Register port reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | TS_W/2 | Register write data |
| regRdData | output | TS_W/2 | Register read data for regAddr |
| refClk | input | 1 | Reference clock for the counter |
| refRstN | input | 1 | Reference domain reset, active low |
| rxPktStrobe | input | 1 | One-cycle strobe per received packet |
| ppmPulse | input | 1 | One-cycle rate correction pulse |
| timeStamp | output | TS_W | Current counter value |
| rxStamp | output | TS_W | Stamp of the most recent stamped packet |
| rxEvent | output | 1 | One-cycle event for a stamped packet |
| syncOut | output | 1 | Selected counter bit |
| compOut | output | 1 | Compare output |

## Verification
A packet strobe and a rate correction pulse can arrive in the same reference cycle. The stamp must take the counter value from before the correction, while the counter itself moves by 2 or by 0. The bench drives both strobes on the same clock, once for each correction direction. It then checks the latched stamp against the value sampled just before the edge, and the new counter value against that same sample plus the step the direction calls for.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

  localparam int SEL_W  = 4;
  localparam int TAP_N  = 2 ** SEL_W;

  // Register addresses
  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_CMP_LO  = 1;
  localparam int ADDR_CMP_HI  = 2;
  localparam int ADDR_LOAD_LO = 3;
  localparam int ADDR_LOAD_HI = 4;

  typedef struct packed {
    logic [SEL_W-1:0] syncSel;
    logic             rxNoEvent;
    logic             rxStampEn;
    logic             compPol;
    logic             compToggle;
    logic             ppmDir;
    logic             seqMode;
    logic             wide64;
    logic             enable;
  } cfg_t;

  localparam int   CFG_W     = $bits(cfg_t);
  localparam cfg_t CFG_RESET = '{syncSel: '0, rxNoEvent: 1'b0, rxStampEn: 1'b0,
                                 compPol: 1'b1, compToggle: 1'b0, ppmDir: 1'b0,
                                 seqMode: 1'b0, wide64: 1'b0, enable: 1'b0};

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic             clear;
    logic             load;
    logic [1:0]       step;
    logic             capture;
    logic             useSeq;
    logic             seqClear;
    logic             emitEvent;
    logic             compFollow;
    logic             compFlip;
    logic             keepUpper;
    logic             compInvert;
    logic [SEL_W-1:0] tapSel;
  } strobe_t;

endpackage

// File: rtl/tsync_regs.sv
module tsync_regs
  import tsync_pkg::*;
#(
  parameter int TS_W   = 64,
  parameter int ADDR_W = 3,
  localparam int REG_W = TS_W / 2
) (
  input  logic              hostClk,
  input  logic              hostRstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output cfg_t              cfg,
  output logic [TS_W-1:0]   cmpVal,
  output logic              loadReq,
  output logic [TS_W-1:0]   loadVal
);

  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_CMP_LO  = ADDR_W'(ADDR_CMP_LO);
  localparam logic [ADDR_W-1:0] A_CMP_HI  = ADDR_W'(ADDR_CMP_HI);
  localparam logic [ADDR_W-1:0] A_LOAD_LO = ADDR_W'(ADDR_LOAD_LO);
  localparam logic [ADDR_W-1:0] A_LOAD_HI = ADDR_W'(ADDR_LOAD_HI);

  cfg_t             ctrlQ;
  logic [REG_W-1:0] cmpLoQ;
  logic [REG_W-1:0] cmpHiQ;
  logic [REG_W-1:0] loadHiQ;

  always_ff @(posedge hostClk or negedge hostRstN) begin
    if (!hostRstN) begin
      ctrlQ   <= CFG_RESET;
      cmpLoQ  <= '0;
      cmpHiQ  <= '0;
      loadHiQ <= '0;
    end else if (wrEn) begin
      case (addr)
        A_CTRL:    ctrlQ   <= cfg_t'(wrData[CFG_W-1:0]);
        A_CMP_LO:  cmpLoQ  <= wrData;
        A_CMP_HI:  cmpHiQ  <= wrData;
        A_LOAD_HI: loadHiQ <= wrData;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_CTRL:    rdData[CFG_W-1:0] = ctrlQ;
      A_CMP_LO:  rdData = cmpLoQ;
      A_CMP_HI:  rdData = cmpHiQ;
      A_LOAD_HI: rdData = loadHiQ;
      default:   rdData = '0;
    endcase
  end

  assign cfg     = ctrlQ;
  assign cmpVal  = {cmpHiQ, cmpLoQ};
  assign loadReq = wrEn && (addr == A_LOAD_LO);
  assign loadVal = {loadHiQ, wrData};

endmodule

// File: rtl/tsync_ctrl.sv
module tsync_ctrl
  import tsync_pkg::*;
(
  input  cfg_t    cfg,
  input  logic    ppmPulse,
  input  logic    rxPktStrobe,
  input  logic    loadReq,
  input  logic    cntMatch,
  output strobe_t stb
);

  always_comb begin
    stb = '0;
    // Disabled enable holds the whole reference domain cleared
    stb.clear      = !cfg.enable;
    stb.load       = loadReq;
    // Correction: direction 0 inserts a count, direction 1 swallows one
    if (ppmPulse) stb.step = cfg.ppmDir ? 2'd0 : 2'd2;
    else          stb.step = 2'd1;
    stb.capture    = cfg.enable && cfg.rxStampEn && rxPktStrobe;
    stb.useSeq     = cfg.seqMode;
    stb.seqClear   = !cfg.seqMode;
    stb.emitEvent  = stb.capture && !cfg.rxNoEvent;
    stb.compFollow = !cfg.compToggle;
    stb.compFlip   = cfg.compToggle && cntMatch;
    stb.keepUpper  = cfg.wide64;
    stb.compInvert = !cfg.compPol;
    stb.tapSel     = cfg.syncSel;
  end

endmodule

// File: rtl/tsync_datapath.sv
module tsync_datapath
  import tsync_pkg::*;
#(
  parameter int TS_W      = 64,
  parameter int SYNC_BASE = 16,
  localparam int HALF_W   = TS_W / 2
) (
  input  logic            refClk,
  input  logic            refRstN,
  input  strobe_t         stb,
  input  logic [TS_W-1:0] loadVal,
  input  logic [TS_W-1:0] cmpVal,
  output logic [TS_W-1:0] timeStamp,
  output logic [TS_W-1:0] rxStamp,
  output logic            rxEvent,
  output logic            syncOut,
  output logic            compOut,
  output logic            cntMatch
);

  logic [TS_W-1:0]  cnt;
  logic [TS_W-1:0]  cntSum;
  logic [TS_W-1:0]  cntNext;
  logic [TS_W-1:0]  seqCnt;
  logic [TS_W-1:0]  seqNext;
  logic             compState;
  logic [TAP_N-1:0] taps;

  // Counter next value
  always_comb begin
    cntSum  = stb.load ? loadVal : cnt + TS_W'(stb.step);
    cntNext = stb.keepUpper ? cntSum : {{HALF_W{1'b0}}, cntSum[HALF_W-1:0]};
  end

  always_ff @(posedge refClk or negedge refRstN) begin
    if (!refRstN)       cnt <= '0;
    else if (stb.clear) cnt <= '0;
    else                cnt <= cntNext;
  end

  // Packet sequence numbering: advanced before presentation
  assign seqNext = seqCnt + TS_W'(1);

  always_ff @(posedge refClk or negedge refRstN) begin
    if (!refRstN)                         seqCnt <= '0;
    else if (stb.clear || stb.seqClear)   seqCnt <= '0;
    else if (stb.capture && stb.useSeq)   seqCnt <= seqNext;
  end

  always_ff @(posedge refClk or negedge refRstN) begin
    if (!refRstN) begin
      rxStamp <= '0;
      rxEvent <= 1'b0;
    end else if (stb.clear) begin
      rxStamp <= '0;
      rxEvent <= 1'b0;
    end else begin
      rxEvent <= stb.emitEvent;
      if (stb.capture) rxStamp <= stb.useSeq ? seqNext : cnt;
    end
  end

  // Compare
  assign cntMatch = (cnt == cmpVal);

  always_ff @(posedge refClk or negedge refRstN) begin
    if (!refRstN)            compState <= 1'b0;
    else if (stb.clear)      compState <= 1'b0;
    else if (stb.compFollow) compState <= cntMatch;
    else if (stb.compFlip)   compState <= !compState;
  end

  assign compOut = compState ^ stb.compInvert;

  // Sync tap selection: entry 0 is the disabled level
  assign taps[0] = 1'b0;
  for (genvar i = 1; i < TAP_N; i++) begin : g_tap
    assign taps[i] = cnt[SYNC_BASE + i];
  end

  assign syncOut   = taps[stb.tapSel];
  assign timeStamp = cnt;

endmodule

// File: rtl/tsync_counter.sv
module tsync_counter
  import tsync_pkg::*;
#(
  parameter int TS_W      = 64,
  parameter int ADDR_W    = 3,
  parameter int SYNC_BASE = 16,
  localparam int REG_W    = TS_W / 2
) (
  input  logic              hostClk,
  input  logic              hostRstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              refClk,
  input  logic              refRstN,
  input  logic              rxPktStrobe,
  input  logic              ppmPulse,
  output logic [TS_W-1:0]   timeStamp,
  output logic [TS_W-1:0]   rxStamp,
  output logic              rxEvent,
  output logic              syncOut,
  output logic              compOut
);

  cfg_t            cfg;
  strobe_t         stb;
  logic [TS_W-1:0] cmpVal;
  logic [TS_W-1:0] loadVal;
  logic            loadReq;
  logic            cntMatch;

  tsync_regs #(.TS_W(TS_W), .ADDR_W(ADDR_W)) i_regs (
    .hostClk (hostClk),
    .hostRstN(hostRstN),
    .wrEn    (regWrEn),
    .addr    (regAddr),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .cfg     (cfg),
    .cmpVal  (cmpVal),
    .loadReq (loadReq),
    .loadVal (loadVal)
  );

  tsync_ctrl i_ctrl (
    .cfg        (cfg),
    .ppmPulse   (ppmPulse),
    .rxPktStrobe(rxPktStrobe),
    .loadReq    (loadReq),
    .cntMatch   (cntMatch),
    .stb        (stb)
  );

  tsync_datapath #(.TS_W(TS_W), .SYNC_BASE(SYNC_BASE)) i_dp (
    .refClk   (refClk),
    .refRstN  (refRstN),
    .stb      (stb),
    .loadVal  (loadVal),
    .cmpVal   (cmpVal),
    .timeStamp(timeStamp),
    .rxStamp  (rxStamp),
    .rxEvent  (rxEvent),
    .syncOut  (syncOut),
    .compOut  (compOut),
    .cntMatch (cntMatch)
  );

endmodule

// File: rtl/tsync_checker.sv
module tsync_checker
  import tsync_pkg::*;
#(
  parameter int TS_W = 64
) (
  input logic            refClk,
  input logic            refRstN,
  input cfg_t            cfg,
  input logic            ppmPulse,
  input logic            rxPktStrobe,
  input logic            loadReq,
  input logic [TS_W-1:0] timeStamp,
  input logic [TS_W-1:0] cmpVal,
  input logic            compOut,
  input logic            rxEvent
);

  assert_hold_R3: assert property (@(posedge refClk) disable iff (!refRstN)
    !cfg.enable |=> (timeStamp == '0));

  assert_count_R4: assert property (@(posedge refClk) disable iff (!refRstN)
    (cfg.enable && cfg.wide64 && !ppmPulse && !loadReq)
      |=> (timeStamp == $past(timeStamp) + TS_W'(1)));

  assert_slip_R5: assert property (@(posedge refClk) disable iff (!refRstN)
    (cfg.enable && cfg.wide64 && ppmPulse && cfg.ppmDir && !loadReq)
      |=> $stable(timeStamp));

  assert_upper_R6: assert property (@(posedge refClk) disable iff (!refRstN)
    !cfg.wide64 |=> (timeStamp[TS_W-1:TS_W/2] == '0));

  assert_pulse_R9: assert property (@(posedge refClk) disable iff (!refRstN)
    (cfg.enable && !cfg.compToggle && (timeStamp == cmpVal))
      |=> (compOut == cfg.compPol));

  assert_noevent_R11: assert property (@(posedge refClk) disable iff (!refRstN)
    (cfg.rxNoEvent || !rxPktStrobe) |=> !rxEvent);

endmodule

bind tsync_counter tsync_checker #(.TS_W(TS_W)) i_checker (
  .refClk     (refClk),
  .refRstN    (refRstN),
  .cfg        (cfg),
  .ppmPulse   (ppmPulse),
  .rxPktStrobe(rxPktStrobe),
  .loadReq    (loadReq),
  .timeStamp  (timeStamp),
  .cmpVal     (cmpVal),
  .compOut    (compOut),
  .rxEvent    (rxEvent)
);

// File: tb/test_tsync_counter.sv
`timescale 1ns/1ps
module test_tsync_counter;

  logic        clk;
  logic        rstN;
  logic        regWrEn;
  logic [2:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        rxPktStrobe;
  logic        ppmPulse;
  logic [63:0] timeStamp;
  logic [63:0] rxStamp;
  logic        rxEvent;
  logic        syncOut;
  logic        compOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  tsync_counter i_tsync_counter (
    .hostClk(clk), .hostRstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .refClk(clk), .refRstN(rstN),
    .rxPktStrobe(rxPktStrobe), .ppmPulse(ppmPulse), .timeStamp(timeStamp),
    .rxStamp(rxStamp), .rxEvent(rxEvent), .syncOut(syncOut), .compOut(compOut)
  );

  typedef struct packed {
    logic       ppm;
    logic       dir;
    logic [1:0] delta;
  } vec_t;

  // R4/R5 step vectors
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 2'd1}, '{1'b1, 1'b0, 2'd2}, '{1'b1, 1'b1, 2'd0}, '{1'b0, 1'b1, 2'd1},
    '{1'b1, 1'b1, 2'd0}, '{1'b1, 1'b0, 2'd2}, '{1'b0, 1'b0, 2'd1}, '{1'b1, 1'b0, 2'd2}
  };

  function automatic logic [31:0] ctl(input logic en, wide, seq, dir, tog, pol,
                                      stEn, noEv, input logic [3:0] sel);
    return {20'd0, sel, noEv, stEn, pol, tog, dir, seq, wide, en};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic loadTs(input logic [63:0] v);
    wr(3'd4, v[63:32]);
    wr(3'd3, v[31:0]);
  endtask

  task automatic strobe(input logic ppm);
    rxPktStrobe = 1'b1; ppmPulse = ppm;
    @(negedge clk);
    rxPktStrobe = 1'b0; ppmPulse = 1'b0;
  endtask

  task automatic compareRun(input string req, input logic toggleMode,
                            input logic pol, inout logic state);
    logic [63:0] prev;
    logic hit;
    loadTs(64'hFD);
    for (int i = 0; i < 6; i++) begin
      prev = timeStamp;
      @(negedge clk);
      hit = (prev == 64'h100);
      if (toggleMode) state = state ^ hit;
      else            state = hit;
      check(req, {63'd0, compOut}, {63'd0, pol ? state : !state});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [63:0] a;
    logic [63:0] held;
    logic st;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    rxPktStrobe = 1'b0; ppmPulse = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regAddr = 3'd0; #0.1;
    check("R1 ctrl", {32'd0, regRdData}, 64'h20);
    check("R1 ts", timeStamp, 0);
    check("R1 comp", {63'd0, compOut}, 0);
    check("R1 sync", {63'd0, syncOut}, 0);
    check("R1 event", {63'd0, rxEvent}, 0);

    // R2 register readback
    wr(3'd1, 32'h0000_0100);
    wr(3'd2, 32'h0);
    wr(3'd4, 32'hA5A5_0001);
    regAddr = 3'd1; #0.1; check("R2 cmpLo", {32'd0, regRdData}, 64'h100);
    regAddr = 3'd4; #0.1; check("R2 loadHi", {32'd0, regRdData}, 64'hA5A5_0001);

    // R3 disabled: loads and packets ignored
    wr(3'd0, ctl(0,1,0,0,0,1,1,0,4'd0));
    loadTs(64'h1234);
    check("R3 ts held", timeStamp, 0);
    strobe(1'b0);
    check("R3 rxStamp", rxStamp, 0);
    check("R3 event", {63'd0, rxEvent}, 0);

    // R4/R5 vector table
    wr(3'd0, ctl(1,1,0,0,0,1,0,0,4'd0));
    foreach (VECS[i]) begin
      wr(3'd0, ctl(1,1,0,VECS[i].dir,0,1,0,0,4'd0));
      a = timeStamp;
      ppmPulse = VECS[i].ppm;
      @(negedge clk);
      ppmPulse = 1'b0;
      check(VECS[i].ppm ? "R5 step" : "R4 step", timeStamp - a, {62'd0, VECS[i].delta});
    end

    // R6/R7 width modes
    loadTs(64'h0000_0000_FFFF_FFFE);
    check("R7 load64", timeStamp, 64'h0000_0000_FFFF_FFFE);
    @(negedge clk); @(negedge clk);
    check("R6 carry64", timeStamp, 64'h1_0000_0000);
    wr(3'd0, ctl(1,0,0,0,0,1,0,0,4'd0));
    loadTs(64'h5_FFFF_FFFE);
    check("R7 load32", timeStamp, 64'hFFFF_FFFE);
    @(negedge clk); @(negedge clk);
    check("R6 wrap32", timeStamp, 64'h0);

    // R8 sync tap
    wr(3'd0, ctl(1,1,0,0,0,1,0,0,4'd1));
    loadTs(64'h0002_0000);   check("R8 sel1 hi", {63'd0, syncOut}, 1);
    loadTs(64'h0001_FF00);   check("R8 sel1 lo", {63'd0, syncOut}, 0);
    wr(3'd0, ctl(1,1,0,0,0,1,0,0,4'd15));
    loadTs(64'h8000_0000);   check("R8 sel15 hi", {63'd0, syncOut}, 1);
    loadTs(64'h7FFF_0000);   check("R8 sel15 lo", {63'd0, syncOut}, 0);
    wr(3'd0, ctl(1,1,0,0,0,1,0,0,4'd0));
    loadTs(64'hFFFF_FFFF_FFFF_0000); check("R8 sel0", {63'd0, syncOut}, 0);

    // R9 pulse mode, both polarities; R10 toggle mode
    st = 1'b0;
    wr(3'd0, ctl(1,1,0,0,0,1,0,0,4'd0));
    compareRun("R9 pulse hi", 1'b0, 1'b1, st);
    wr(3'd0, ctl(1,1,0,0,0,0,0,0,4'd0));
    compareRun("R9 pulse lo", 1'b0, 1'b0, st);
    wr(3'd0, ctl(1,1,0,0,1,1,0,0,4'd0));
    st = 1'b0;
    compareRun("R10 toggle 1", 1'b1, 1'b1, st);
    compareRun("R10 toggle 2", 1'b1, 1'b1, st);

    // R11 receive stamping and events
    wr(3'd0, ctl(1,1,0,0,0,1,1,0,4'd0));
    a = timeStamp; strobe(1'b0);
    check("R11 stamp", rxStamp, a);
    check("R11 event", {63'd0, rxEvent}, 1);
    @(negedge clk);
    check("R11 event one", {63'd0, rxEvent}, 0);
    wr(3'd0, ctl(1,1,0,0,0,1,1,1,4'd0));
    a = timeStamp; strobe(1'b0);
    check("R11 noev stamp", rxStamp, a);
    check("R11 noev event", {63'd0, rxEvent}, 0);
    wr(3'd0, ctl(1,1,0,0,0,1,0,0,4'd0));
    held = rxStamp; strobe(1'b0);
    check("R11 off stamp", rxStamp, held);
    check("R11 off event", {63'd0, rxEvent}, 0);

    // R12 sequence numbering
    wr(3'd0, ctl(1,1,1,0,0,1,1,0,4'd0));
    rxPktStrobe = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      check("R12 seq", rxStamp, 64'(k));
    end
    rxPktStrobe = 1'b0;
    @(negedge clk);
    strobe(1'b0);
    check("R12 seq gap", rxStamp, 4);
    wr(3'd0, ctl(1,1,0,0,0,1,1,0,4'd0));
    wr(3'd0, ctl(1,1,1,0,0,1,1,0,4'd0));
    strobe(1'b0);
    check("R12 restart", rxStamp, 1);

    // R13 packet strobe coinciding with correction
    wr(3'd0, ctl(1,1,0,0,0,1,1,0,4'd0));
    a = timeStamp; strobe(1'b1);
    check("R13 stamp add", rxStamp, a);
    check("R13 ts add", timeStamp, a + 2);
    wr(3'd0, ctl(1,1,0,1,0,1,1,0,4'd0));
    a = timeStamp; strobe(1'b1);
    check("R13 stamp drop", rxStamp, a);
    check("R13 ts drop", timeStamp, a);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule